// File: doc/BRIEF.md
# Prescaled Free-Running Timebase with Periodic Tick

This block keeps a free-running count that software can read but never load or stop. The count advances once for every prescaled step of the system clock. The step size is selected as 1, 4, 8 or 16 system cycles. A sticky overflow flag is raised each time the count wraps from all ones back to zero, so software can extend its range by counting wraps.

Beside the counter, a second divider gives a periodic tick with its own sticky flag. It divides the system clock by a fixed power of two (4096 by default) and then by a further 1, 2, 4 or 8. Each flag has an enable, and the enabled flags are combined into a single interrupt request.

Software reaches the block through a byte-wide register port with four addresses. Reading the count takes two byte reads. Reading the upper part first freezes the lower byte, so the two reads give one coherent value.

Top module: `tc_timebase`

## Requirements
- R1: The count changes only by stepping up one, wrapping from all ones to zero. Writes to the count addresses (0 and 1) have no effect on it.
- R2: Control bits [1:0] set the prescale factor: 00, 01, 10 and 11 give one count step every 1, 4, 8 and 16 system cycles.
- R3: Status bit 0 (overflow flag) sets at the clock edge where the count goes from all ones to zero, and it stays set.
- R4: Writing to the status address (3) clears each flag whose bit is written as 1. Bit 0 is overflow and bit 1 is tick. A flag written as 0 is left unchanged.
- R5: If a flag's set event and a clear of that flag fall in the same cycle, the flag ends up set.
- R6: Status bit 1 (tick flag) sets once every 2^TICK_LOG2 × {1, 2, 4, 8} system cycles. The factor is selected by control bits [3:2] = 00, 01, 10, 11.
- R7: irq is high exactly when the overflow flag is set with control bit 4 high, or the tick flag is set with control bit 5 high.
- R8: A read of address 0 returns the count bits above bit 7 and captures the low byte. The next read of address 1 returns that captured byte. A read of address 1 with nothing captured returns the live low byte.
- R9: After reset the count is zero, the control register and both flags are zero, and irq is low.
- R10: The control register (address 2) reads back bits [5:0] as written, and bits [7:6] read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers the capture behaviour) |
| bus_addr | input | 2 | Register address: 0 count high, 1 count low, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with a 10-bit count (CNT_W = 10) and a 64-cycle tick base (TICK_LOG2 = 6). With these values a wrap takes at most 16384 cycles and a tick at most 512. This makes it practical to sweep every prescale and every tick select, and to measure whole wrap and tick periods exactly. The narrow count also lets the bench compute the full count value from two byte reads. It can then aim a flag clear at the exact cycle of a wrap.

// File: rtl/tc_pkg.sv
package tc_pkg;
   localparam int BUS_W    = 8;
   localparam int FLAG_N   = 2;
   localparam int OVF_BIT  = 0;
   localparam int TICK_BIT = 1;
   localparam int PRE_W    = 4;   // widest prescale is 2^4
   localparam int PRE_LGW  = 3;

   typedef enum logic [1:0] {
      A_CNT_HI = 2'd0,
      A_CNT_LO = 2'd1,
      A_CTRL   = 2'd2,
      A_STAT   = 2'd3
   } tc_addr_e;

   typedef struct packed {
      logic       tick_ie;
      logic       ovf_ie;
      logic [1:0] tick_sel;
      logic [1:0] pre_sel;
   } tc_ctrl_t;

   localparam int CTRL_W = $bits(tc_ctrl_t);

   function automatic logic [PRE_LGW-1:0] pre_log2(input logic [1:0] sel);
      case (sel)
         2'd0:    return 3'd0;
         2'd1:    return 3'd2;
         2'd2:    return 3'd3;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/tc_divider.sv
module tc_divider #(
   parameter int W   = 4,
   parameter int LGW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [LGW-1:0] lg,
   output logic           pulse
);
   logic [W-1:0] q;
   logic [W-1:0] mask;

   generate
      if (W < 1) begin : g_bad
         $error("tc_divider: W must be at least 1");
      end
      if ((1 << LGW) <= W) begin : g_badlg
         $error("tc_divider: LGW too narrow for W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q + 1'b1;
   end

   assign mask  = ~({W{1'b1}} << lg);
   assign pulse = ((q & mask) == mask);
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap_evt
);
   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end

   assign wrap_evt = step & (&cnt);
endmodule

// File: rtl/tc_flags.sv
module tc_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;   // set beats clear
         else if (clr[i]) q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/tc_regs.sv
module tc_regs
   import tc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [FLAG_N-1:0] flags,
   output tc_ctrl_t          ctrl,
   output logic [FLAG_N-1:0] flag_clr
);
   localparam int HI_W = CNT_W - BUS_W;

   logic [BUS_W-1:0] lo_hold;
   logic             hold_v;
   logic             unused_wbits;

   assign unused_wbits = ^bus_wdata[BUS_W-1:CTRL_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl    <= '0;
         lo_hold <= '0;
         hold_v  <= 1'b0;
      end else begin
         if (bus_wr && bus_addr == A_CTRL)
            ctrl <= tc_ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (bus_rd && bus_addr == A_CNT_HI) begin
            lo_hold <= cnt[BUS_W-1:0];
            hold_v  <= 1'b1;
         end else if (bus_rd && bus_addr == A_CNT_LO) begin
            hold_v  <= 1'b0;
         end
      end
   end

   assign flag_clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata[FLAG_N-1:0] : '0;

   always_comb begin
      case (bus_addr)
         A_CNT_HI: bus_rdata = BUS_W'(cnt[CNT_W-1:BUS_W]);
         A_CNT_LO: bus_rdata = hold_v ? lo_hold : cnt[BUS_W-1:0];
         A_CTRL:   bus_rdata = BUS_W'(ctrl);
         default:  bus_rdata = BUS_W'(flags);
      endcase
   end

   generate
      if (HI_W < 1 || HI_W > BUS_W) begin : g_badw
         $error("tc_regs: count must span more than one and at most two bytes");
      end
   endgenerate
endmodule

// File: rtl/tc_timebase.sv
module tc_timebase
   import tc_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int TICK_LOG2 = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [1:0]  bus_addr,
   input  logic [7:0]  bus_wdata,
   output logic [7:0]  bus_rdata,
   output logic        irq
);
   localparam int TDIV_W = TICK_LOG2 + 3;
   localparam int TLG_W  = $clog2(TDIV_W + 1);

   generate
      if (CNT_W <= BUS_W || CNT_W > 2 * BUS_W) begin : g_badcnt
         $error("tc_timebase: CNT_W must lie in (BUS_W, 2*BUS_W]");
      end
      if (TICK_LOG2 < 1) begin : g_badtick
         $error("tc_timebase: TICK_LOG2 must be positive");
      end
   endgenerate

   tc_ctrl_t            ctrl;
   logic                pre_pulse;
   logic                tick_pulse;
   logic                wrap_evt;
   logic [CNT_W-1:0]    cnt_q;
   logic [FLAG_N-1:0]   flag_q;
   logic [FLAG_N-1:0]   flag_set;
   logic [FLAG_N-1:0]   flag_clr;
   logic [FLAG_N-1:0]   flag_en;
   logic [TLG_W-1:0]    tick_lg;

   assign tick_lg = TLG_W'(TICK_LOG2) + TLG_W'(ctrl.tick_sel);

   tc_divider #(.W(PRE_W), .LGW(PRE_LGW)) u_pre (
      .clk(clk), .rst_n(rst_n), .lg(pre_log2(ctrl.pre_sel)), .pulse(pre_pulse)
   );

   tc_divider #(.W(TDIV_W), .LGW(TLG_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .lg(tick_lg), .pulse(tick_pulse)
   );

   tc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(pre_pulse), .cnt(cnt_q), .wrap_evt(wrap_evt)
   );

   always_comb begin
      flag_set           = '0;
      flag_set[OVF_BIT]  = wrap_evt;
      flag_set[TICK_BIT] = tick_pulse;
      flag_en            = '0;
      flag_en[OVF_BIT]   = ctrl.ovf_ie;
      flag_en[TICK_BIT]  = ctrl.tick_ie;
   end

   tc_flags #(.N(FLAG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .q(flag_q)
   );

   tc_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt(cnt_q), .flags(flag_q), .ctrl(ctrl), .flag_clr(flag_clr)
   );

   assign irq = |(flag_q & flag_en);
endmodule

// File: rtl/tc_timebase_chk.sv
module tc_timebase_chk
   import tc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [1:0]       bus_addr,
   input logic [7:0]       bus_wdata,
   input logic [CNT_W-1:0] cnt,
   input logic [1:0]       flags,
   input logic             irq
);
   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

   // R3
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt) ##1 (cnt == '0) |-> flags[OVF_BIT]);

   // R4
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[OVF_BIT] && !(bus_wr && bus_addr == A_STAT && bus_wdata[OVF_BIT]))
      |=> flags[OVF_BIT]);

   // R4
   tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[TICK_BIT] && !(bus_wr && bus_addr == A_STAT && bus_wdata[TICK_BIT]))
      |=> flags[TICK_BIT]);

   // R7
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == 2'b00) |-> !irq);

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (cnt == '0 && flags == 2'b00));
endmodule

bind tc_timebase tc_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .cnt(cnt_q), .flags(flag_q), .irq(irq)
);

// File: tb/tb_tc_timebase.sv
module tb_tc_timebase;
   localparam int CNT_W     = 10;
   localparam int TICK_LOG2 = 6;
   localparam int CNT_MOD   = 1 << CNT_W;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_wr, bus_rd;
   logic [1:0] bus_addr;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic       irq;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;
   int last_cyc;
   logic last_irq;

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc <= cyc + 1;

   tc_timebase #(.CNT_W(CNT_W), .TICK_LOG2(TICK_LOG2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // One bus cycle, entered and left at a falling edge.
   task automatic bus_op(input logic wr, input logic [1:0] a, input logic [7:0] d,
                         output logic [7:0] r);
      bus_wr = wr; bus_rd = !wr; bus_addr = a; bus_wdata = d;
      #1;
      r = bus_rdata; last_cyc = cyc; last_irq = irq;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] r);
      bus_op(1'b0, a, 8'h00, r);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      logic [7:0] dummy;
      bus_op(1'b1, a, d, dummy);
   endtask

   task automatic wait_flag(input int b, output int t);
      logic [7:0] s;
      for (int i = 0; i < 40000; i++) begin
         rd(2'd3, s);
         if (s[b]) begin t = last_cyc; return; end
      end
      chk("flag wait timeout", 0, 1);
      t = 0;
   endtask

   // Cycles between count steps, measured between the 2nd and 3rd change.
   task automatic step_interval(output int n, output int delta);
      logic [7:0] prev, cur;
      int changes = 0;
      n = 0; delta = 0;
      rd(2'd1, prev);
      while (changes < 3) begin
         rd(2'd1, cur);
         n++;
         if (cur != prev) begin
            changes++;
            if (changes == 3) delta = int'(8'(cur - prev));
            else n = 0;
            prev = cur;
         end
         if (n > 100) begin delta = -1; return; end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual expired expected finish");
      finish_up();
   end

   initial begin
      logic [7:0] r, v, h, l;
      int n, d, t1, t2, b, k;
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      rd(2'd2, r); chk("R9 ctrl after reset", r, 0);
      rd(2'd3, r); chk("R9 status after reset", r, 0);
      chk("R9 irq after reset", last_irq, 0);
      rd(2'd0, r); chk("R9 count high after reset", r, 0);
      rd(2'd1, r); chk("R9 count low near reset", int'(r < 8'd8), 1);

      // R10 control readback
      wr(2'd2, 8'hFF); rd(2'd2, r); chk("R10 ctrl upper bits zero", r, 8'h3F);
      wr(2'd2, 8'h2D); rd(2'd2, r); chk("R10 ctrl readback", r, 8'h2D);

      // R2 / R1 prescale sweep
      for (int s = 0; s < 4; s++) begin
         int f;
         f = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
         wr(2'd2, 8'(s));
         step_interval(n, d);
         chk($sformatf("R2 step period sel %0d", s), n, f);
         chk($sformatf("R1 step size sel %0d", s), d, 1);
      end

      // R1 writes to count ignored
      wr(2'd2, 8'h00);
      rd(2'd1, v);
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'h00);
      rd(2'd1, r); chk("R1 count unaffected by writes", r, 8'(v + 8'd3));

      // R8 coherent two-byte read
      rd(2'd1, v);
      rd(2'd0, h);
      rd(2'd1, r); chk("R8 low byte held after high read", r, 8'(v + 8'd1));
      rd(2'd1, r); chk("R8 low byte live after hold consumed", r, 8'(v + 8'd3));

      // R3 / R4 overflow with prescale 4
      wr(2'd2, 8'h01);
      wr(2'd3, 8'h03);
      wait_flag(0, t1);
      wr(2'd3, 8'h01);
      wait_flag(0, t2);
      chk("R3 wrap period prescale 4", t2 - t1, CNT_MOD * 4);
      rd(2'd1, r); chk("R3 count low right after wrap", r, 0);
      rd(2'd0, r); chk("R3 count high right after wrap", r, 0);
      rd(2'd1, r);
      wr(2'd3, 8'h00);
      rd(2'd3, r); chk("R4 write 0 keeps overflow flag", r[0], 1);
      wr(2'd3, 8'h01);
      rd(2'd3, r); chk("R4 write 1 clears overflow flag", r[0], 0);

      // R3 overflow with prescale 16
      wr(2'd2, 8'h03);
      wr(2'd3, 8'h01);
      wait_flag(0, t1);
      wr(2'd3, 8'h01);
      wait_flag(0, t2);
      chk("R3 wrap period prescale 16", t2 - t1, CNT_MOD * 16);

      // R5 set wins over a clear in the same cycle
      wr(2'd2, 8'h00);
      wr(2'd3, 8'h01);
      wait_flag(0, t1);
      rd(2'd0, h);
      rd(2'd1, l);
      b = int'(h) * 256 + int'(l);
      k = (CNT_MOD - 1 - b) % CNT_MOD;
      if (k < 0) k += CNT_MOD;
      if (k < 2) k += CNT_MOD;
      repeat (k - 2) @(negedge clk);
      wr(2'd3, 8'h01);
      rd(2'd3, r); chk("R5 set wins over same-cycle clear", r[0], 1);

      // R6 tick period sweep
      for (int s = 0; s < 4; s++) begin
         wr(2'd2, 8'(s << 2));
         wr(2'd3, 8'h02);
         wait_flag(1, t1);
         wr(2'd3, 8'h02);
         wait_flag(1, t2);
         chk($sformatf("R6 tick period sel %0d", s), t2 - t1, (1 << TICK_LOG2) << s);
      end

      // R7 interrupt gating
      wr(2'd2, 8'h10);
      wr(2'd3, 8'h03);
      wait_flag(0, t1);
      chk("R7 irq with overflow enabled", last_irq, 1);
      wr(2'd2, 8'h00);
      rd(2'd3, r); chk("R7 irq low with enables off", last_irq, 0);
      wr(2'd2, 8'h20);
      wr(2'd3, 8'h03);
      wait_flag(1, t1);
      chk("R7 irq with tick enabled", last_irq, 1);
      wr(2'd3, 8'h02);
      rd(2'd3, r); chk("R7 irq low after tick cleared", last_irq, 0);

      finish_up();
   end
endmodule